// File: doc/BRIEF.md
# Dual-Edge Strobe Capture FIFO

This block sits behind the read path of a double-data-rate memory interface. The memory returns data together with a source-synchronous strobe. Logic upstream delays that strobe so that its edges land in the middle of each data word. On every strobe edge, rising or falling, the block latches the data bus into plain registers. The captured words go into a small first-in first-out store, and the system side reads them out on its own, unrelated clock. The strobe is not a clock in the usual sense. It toggles only while the memory drives data and can stop for any length of time, so the write side never assumes a steady edge rate.

A capture window input qualifies the strobe. Edges seen while the window is low are treated as preamble or postamble and change nothing. Rising-edge words and falling-edge words go into two separate register banks, each with its own pointer. The system side reads the banks alternately, so words leave in the order they arrived: rising word, then the falling word that followed it. Pointers cross between the domains as Gray code through two-flop synchronisers. If a word pair arrives while the store is full, the pair is discarded and a sticky overflow flag is raised.

Top module: `dqs_capture_fifo`

## Requirements
- R1: Reset is held high across at least two strobe cycles with the window low. Directly after reset, empty is 1, full is 0 and overflow is 0.
- R2: Each strobe edge seen with the window high stores one data word. The word from a rising edge is read out before the word from the falling edge that follows it, and words leave in arrival order.
- R3: With 8 words held, the write side discards any further window pair (rising word and its falling word) and sets overflow. Overflow stays 1 until reset, and the 8 stored words are read back unchanged.
- R4: Strobe edges seen while the window is low store nothing.
- R5: While empty is 0, rd_data shows the oldest unread word and holds it until a read. Each system clock cycle with rd_en high pops one word.
- R6: rd_en while empty is 1 has no effect: no word is lost or skipped.
- R7: full is 1 exactly when 8 words are held as seen by the system side. empty and full are never 1 together.
- R8: The strobe may run at any half-period and may pause for any time inside or between windows without changing the stored words.
- R9: Space freed by reads becomes usable by the write side once two rising strobe edges have passed, for example a two-cycle preamble. After the store is drained, a following 8-word burst with such a preamble is accepted without overflow.
- R10: Reads in the system domain may run during strobe writes. No word is lost or duplicated, and overflow stays 0 while the store never fills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the read side |
| rst | input | 1 | Active-high synchronous reset, sampled by sys_clk and by strobe edges |
| strb_dly | input | 1 | Delayed, centred data strobe; both edges capture |
| dq_in | input | DATA_W | Data bus from the memory |
| cap_win | input | 1 | Capture window; edges count only while high |
| rd_en | input | 1 | Pop request, system domain |
| rd_data | output | DATA_W | Oldest unread word (show-ahead) |
| empty | output | 1 | No unread word visible to the system side |
| full | output | 1 | Eight words held |
| overflow | output | 1 | Sticky: a window pair was discarded |

## Verification
The collision that matters is a strobe-domain write landing in the same system cycle as a pop. The pop moves the read pointer, and the pointer that feeds the write side's space check is being sampled on strobe edges at the same time. The bench provokes this by running a reader that pops the moment empty drops, in parallel with three strobe bursts of different half-periods. Each popped word is compared with a scoreboard filled at the strobe edge, and overflow must stay 0. A second collision case is a pair arriving at a store that is already full while the system side is idle. It is judged by checking that overflow rises, that the eight earlier words come back unchanged, and that the flag survives the drain.

// File: rtl/dqscap_pkg.sv
package dqscap_pkg;

    localparam int unsigned DQ_W_DEF    = 16;
    localparam int unsigned DEPTH_DEF   = 8;
    localparam int unsigned SYNC_STAGES = 2;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } strobe_edge_e;

    typedef struct packed {
        logic empty;
        logic full;
    } rd_flags_t;

    // number of slots served by one strobe edge
    function automatic int unsigned bank_slots(input int unsigned depth);
        return depth / 2;
    endfunction

    // pointer width with one wrap bit
    function automatic int unsigned wrap_ptr_w(input int unsigned entries);
        return $clog2(entries) + 1;
    endfunction

endpackage

// File: rtl/dqscap_sync.sv
module dqscap_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = dqscap_pkg::SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dqscap_edge_writer.sv
module dqscap_edge_writer
    import dqscap_pkg::*;
#(
    parameter strobe_edge_e EDGE   = EDGE_RISE,
    parameter int unsigned  DATA_W = DQ_W_DEF,
    parameter int unsigned  SLOTS  = 4,
    localparam int unsigned IW     = $clog2(SLOTS),
    localparam int unsigned PW     = IW + 1
) (
    input  logic                          strb,
    input  logic                          rst,
    input  logic                          win,
    input  logic                          allow,
    input  logic [DATA_W-1:0]             din,
    output logic [PW-1:0]                 ptr_bin,
    output logic [PW-1:0]                 ptr_gray,
    output logic [SLOTS-1:0][DATA_W-1:0]  slots_q,
    output logic                          refused
);
    logic [PW-1:0]     ptr_q;
    logic [PW-1:0]     gray_q;
    logic [PW-1:0]     ptr_inc;
    logic [PW-1:0]     gray_inc;
    logic              refused_q;
    logic              take;
    logic              drop;
    logic [DATA_W-1:0] mem_q [SLOTS];

    assign take     = win & allow;
    assign drop     = win & ~allow;
    assign ptr_inc  = ptr_q + 1'b1;
    assign gray_inc = ptr_inc ^ (ptr_inc >> 1);

    generate
        if (EDGE == EDGE_RISE) begin : g_rise
            always_ff @(posedge strb) begin
                if (rst) begin
                    ptr_q     <= '0;
                    gray_q    <= '0;
                    refused_q <= 1'b0;
                end else begin
                    if (take) begin
                        mem_q[ptr_q[IW-1:0]] <= din;
                        ptr_q  <= ptr_inc;
                        gray_q <= gray_inc;
                    end
                    if (drop) refused_q <= 1'b1;
                end
            end
        end else begin : g_fall
            always_ff @(negedge strb) begin
                if (rst) begin
                    ptr_q     <= '0;
                    gray_q    <= '0;
                    refused_q <= 1'b0;
                end else begin
                    if (take) begin
                        mem_q[ptr_q[IW-1:0]] <= din;
                        ptr_q  <= ptr_inc;
                        gray_q <= gray_inc;
                    end
                    if (drop) refused_q <= 1'b1;
                end
            end
        end
    endgenerate

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign slots_q[s] = mem_q[s];
    end

    assign ptr_bin  = ptr_q;
    assign ptr_gray = gray_q;
    assign refused  = refused_q;
endmodule

// File: rtl/dqscap_read_ctrl.sv
module dqscap_read_ctrl
    import dqscap_pkg::*;
#(
    parameter int unsigned  DEPTH = DEPTH_DEF,
    localparam int unsigned PAIRS = bank_slots(DEPTH),
    localparam int unsigned PW    = wrap_ptr_w(PAIRS),
    localparam int unsigned WW    = wrap_ptr_w(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [PW-1:0] rise_gray_s,
    input  logic [PW-1:0] fall_gray_s,
    output logic [WW-1:0] rd_ptr,
    output logic [PW-1:0] pair_gray,
    output logic [WW-1:0] occ,
    output rd_flags_t     flags
);
    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [PW-1:0] rise_b;
    logic [PW-1:0] fall_b;
    logic [PW-1:0] lead;
    logic [WW-1:0] wcount;
    logic [WW-1:0] rd_ptr_q;
    logic [WW-1:0] rd_ptr_nx;
    logic [PW-1:0] pair_nx;
    logic [PW-1:0] pair_gray_q;
    logic          pop;

    assign rise_b = g2b(rise_gray_s);
    assign fall_b = g2b(fall_gray_s);
    assign lead   = rise_b - fall_b;

    // words written = 2 * falling count + pending rising word; a rising
    // pointer that looks behind yields the smaller, safe count
    always_comb begin
        if (lead == PW'(1))      wcount = {fall_b, 1'b1};
        else if (lead == '0)     wcount = {fall_b, 1'b0};
        else                     wcount = {fall_b, 1'b0} - 1'b1;
    end

    assign occ         = wcount - rd_ptr_q;
    assign flags.empty = (occ == '0);
    assign flags.full  = (occ == WW'(DEPTH));
    assign pop         = rd_en & ~flags.empty;
    assign rd_ptr_nx   = pop ? rd_ptr_q + 1'b1 : rd_ptr_q;
    assign pair_nx     = rd_ptr_nx[WW-1:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr_q    <= '0;
            pair_gray_q <= '0;
        end else begin
            rd_ptr_q    <= rd_ptr_nx;
            pair_gray_q <= pair_nx ^ (pair_nx >> 1);
        end
    end

    assign rd_ptr    = rd_ptr_q;
    assign pair_gray = pair_gray_q;
endmodule

// File: rtl/dqs_capture_fifo.sv
module dqs_capture_fifo
    import dqscap_pkg::*;
#(
    parameter int unsigned  DATA_W = DQ_W_DEF,
    parameter int unsigned  DEPTH  = DEPTH_DEF,
    localparam int unsigned PAIRS  = bank_slots(DEPTH),
    localparam int unsigned IW     = $clog2(PAIRS),
    localparam int unsigned PW     = wrap_ptr_w(PAIRS),
    localparam int unsigned WW     = wrap_ptr_w(DEPTH)
) (
    input  logic              sys_clk,
    input  logic              rst,
    input  logic              strb_dly,
    input  logic [DATA_W-1:0] dq_in,
    input  logic              cap_win,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              full,
    output logic              overflow
);
    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    // strobe domain
    logic [PW-1:0]                rise_ptr, fall_ptr;
    logic [PW-1:0]                rise_gray, fall_gray;
    logic [PAIRS-1:0][DATA_W-1:0] rise_slots, fall_slots;
    logic                         rise_refused, fall_refused;
    logic                         rise_room, fall_partner;
    logic [PW-1:0]                rdpair_gray_s, rdpair_bin_s;
    logic [PW-1:0]                pair_lead;

    // system domain
    logic [PW-1:0]                rise_gray_s, fall_gray_s;
    logic [PW-1:0]                pair_gray;
    logic [WW-1:0]                rd_ptr, occ;
    logic [IW-1:0]                head_idx;
    rd_flags_t                    flags;
    logic                         refused_any;
    logic                         ovf_s;

    assign rdpair_bin_s = g2b(rdpair_gray_s);
    assign pair_lead    = rise_ptr - rdpair_bin_s;
    assign rise_room    = (pair_lead != PW'(PAIRS));
    assign fall_partner = (fall_ptr != rise_ptr);

    dqscap_edge_writer #(
        .EDGE   (EDGE_RISE),
        .DATA_W (DATA_W),
        .SLOTS  (PAIRS)
    ) u_rise (
        .strb     (strb_dly),
        .rst      (rst),
        .win      (cap_win),
        .allow    (rise_room),
        .din      (dq_in),
        .ptr_bin  (rise_ptr),
        .ptr_gray (rise_gray),
        .slots_q  (rise_slots),
        .refused  (rise_refused)
    );

    dqscap_edge_writer #(
        .EDGE   (EDGE_FALL),
        .DATA_W (DATA_W),
        .SLOTS  (PAIRS)
    ) u_fall (
        .strb     (strb_dly),
        .rst      (rst),
        .win      (cap_win),
        .allow    (fall_partner),
        .din      (dq_in),
        .ptr_bin  (fall_ptr),
        .ptr_gray (fall_gray),
        .slots_q  (fall_slots),
        .refused  (fall_refused)
    );

    dqscap_sync #(.W(PW)) u_rdpair_sync (
        .clk (strb_dly),
        .rst (rst),
        .d   (pair_gray),
        .q   (rdpair_gray_s)
    );

    dqscap_sync #(.W(PW)) u_rise_sync (
        .clk (sys_clk),
        .rst (rst),
        .d   (rise_gray),
        .q   (rise_gray_s)
    );

    dqscap_sync #(.W(PW)) u_fall_sync (
        .clk (sys_clk),
        .rst (rst),
        .d   (fall_gray),
        .q   (fall_gray_s)
    );

    assign refused_any = rise_refused | fall_refused;

    dqscap_sync #(.W(1)) u_ovf_sync (
        .clk (sys_clk),
        .rst (rst),
        .d   (refused_any),
        .q   (ovf_s)
    );

    dqscap_read_ctrl #(.DEPTH(DEPTH)) u_rd (
        .clk         (sys_clk),
        .rst         (rst),
        .rd_en       (rd_en),
        .rise_gray_s (rise_gray_s),
        .fall_gray_s (fall_gray_s),
        .rd_ptr      (rd_ptr),
        .pair_gray   (pair_gray),
        .occ         (occ),
        .flags       (flags)
    );

    assign head_idx = rd_ptr[IW:1];
    assign rd_data  = rd_ptr[0] ? fall_slots[head_idx] : rise_slots[head_idx];
    assign empty    = flags.empty;
    assign full     = flags.full;
    assign overflow = ovf_s;
endmodule

// File: rtl/dqs_capture_fifo_chk.sv
module dqs_capture_fifo_chk #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned PW     = 3,
    parameter int unsigned WW     = 4
) (
    input logic              sys_clk,
    input logic              strb,
    input logic              rst,
    input logic              rd_en,
    input logic              empty,
    input logic              full,
    input logic              overflow,
    input logic [DATA_W-1:0] rd_data,
    input logic [WW-1:0]     rd_ptr,
    input logic [WW-1:0]     occ,
    input logic [PW-1:0]     rise_ptr,
    input logic [PW-1:0]     fall_ptr,
    input logic [PW-1:0]     rdpair_bin_s
);
    logic [PW-1:0] write_lead;
    logic [PW-1:0] edge_lead;

    assign write_lead = rise_ptr - rdpair_bin_s;
    assign edge_lead  = rise_ptr - fall_ptr;

    assert_not_empty_and_full_R7: assert property (@(posedge sys_clk) disable iff (rst)
        !(empty && full));

    assert_occ_bound_R7: assert property (@(posedge sys_clk) disable iff (rst)
        occ <= WW'(DEPTH));

    assert_empty_read_ignored_R6: assert property (@(posedge sys_clk) disable iff (rst)
        (rd_en && empty) |=> (rd_ptr == $past(rd_ptr)));

    assert_head_hold_R5: assert property (@(posedge sys_clk) disable iff (rst)
        (!empty && !rd_en) |=> (rd_data == $past(rd_data)));

    assert_overflow_sticky_R3: assert property (@(posedge sys_clk) disable iff (rst)
        overflow |=> overflow);

    assert_write_room_R3: assert property (@(posedge strb) disable iff (rst)
        write_lead <= PW'(DEPTH / 2));

    assert_pair_order_R2: assert property (@(negedge strb) disable iff (rst)
        edge_lead <= PW'(1));
endmodule

bind dqs_capture_fifo dqs_capture_fifo_chk #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .PW     (PW),
    .WW     (WW)
) u_chk (
    .sys_clk      (sys_clk),
    .strb         (strb_dly),
    .rst          (rst),
    .rd_en        (rd_en),
    .empty        (empty),
    .full         (full),
    .overflow     (overflow),
    .rd_data      (rd_data),
    .rd_ptr       (rd_ptr),
    .occ          (occ),
    .rise_ptr     (rise_ptr),
    .fall_ptr     (fall_ptr),
    .rdpair_bin_s (rdpair_bin_s)
);

// File: tb/dqs_capture_fifo_tb.sv
`timescale 1ns/1ps
module dqs_capture_fifo_tb;
    localparam int DW = 16;

    logic          sys_clk = 1'b0;
    logic          rst = 1'b1;
    logic          strb_dly = 1'b0;
    logic [DW-1:0] dq_in = '0;
    logic          cap_win = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic          empty, full, overflow;

    int n_chk = 0;
    int n_bad = 0;
    logic [DW-1:0] exp_q [$];

    dqs_capture_fifo #(.DATA_W(DW), .DEPTH(8)) u_dut (
        .sys_clk (sys_clk), .rst (rst), .strb_dly (strb_dly), .dq_in (dq_in),
        .cap_win (cap_win), .rd_en (rd_en), .rd_data (rd_data),
        .empty (empty), .full (full), .overflow (overflow)
    );

    always #2 sys_clk = ~sys_clk;   // 250 MHz

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge sys_clk);
    endtask

    // one strobe cycle: rising edge carries a, falling edge carries b
    task automatic strb_pair(input logic [DW-1:0] a, input logic [DW-1:0] b,
                             input int half, input bit keep);
        dq_in = a;
        #(half / 2) strb_dly = 1'b1;
        if (keep) exp_q.push_back(a);
        #(half - half / 2) dq_in = b;
        #(half / 2) strb_dly = 1'b0;
        if (keep) exp_q.push_back(b);
        #(half - half / 2);
    endtask

    task automatic burst(input int pairs, input int keep_pairs, input logic [DW-1:0] base,
                         input int half, input int stall_ns);
        cap_win = 1'b0;
        strb_pair(16'hDEAD, 16'hBEEF, half, 1'b0);
        strb_pair(16'hDEAD, 16'hBEEF, half, 1'b0);
        cap_win = 1'b1;
        for (int p = 0; p < pairs; p++) begin
            strb_pair(base + DW'(2 * p), base + DW'(2 * p + 1), half, p < keep_pairs);
            if (p == 0 && stall_ns > 0) #(stall_ns);
        end
        cap_win = 1'b0;
        strb_pair(16'hBAD0, 16'hBAD1, half, 1'b0);
    endtask

    task automatic pop_check(input string req);
        int waited = 0;
        while (empty && waited < 60) begin
            @(negedge sys_clk);
            waited++;
        end
        if (empty) begin
            n_chk++; n_bad++;
            $display("FAIL %s: actual empty=1 expected a word", req);
        end else begin
            chk(req, rd_data, exp_q.pop_front());
            rd_en = 1'b1;
            @(negedge sys_clk);
            rd_en = 1'b0;
        end
    endtask

    task automatic drain(input int n, input string req);
        for (int i = 0; i < n; i++) pop_check(req);
        settle(1);
        chk({req, " empty after drain"}, empty, 1);
    endtask

    task automatic do_reset();
        rst = 1'b1; cap_win = 1'b0; rd_en = 1'b0;
        repeat (3) strb_pair(16'h0, 16'h0, 4, 1'b0);
        settle(4);
        rst = 1'b0;
        exp_q.delete();
        settle(2);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 empty", empty, 1);
        chk("R1 full", full, 0);
        chk("R1 overflow", overflow, 0);
    endtask

    task automatic t_basic_order();
        burst(2, 2, 16'h1000, 4, 0);
        settle(6);
        chk("R5 not empty", empty, 0);
        chk("R5 head", rd_data, 16'h1000);
        settle(3);
        chk("R5 head held", rd_data, 16'h1000);
        drain(4, "R2 order");
    endtask

    task automatic t_window_gating();
        cap_win = 1'b0;
        repeat (4) strb_pair(16'hF00D, 16'hFACE, 4, 1'b0);
        settle(6);
        chk("R4 outside window", empty, 1);
        burst(1, 1, 16'h2000, 6, 0);
        settle(6);
        drain(2, "R4 pre/postamble");
    endtask

    task automatic t_empty_read();
        for (int i = 0; i < 3; i++) begin
            rd_en = 1'b1;
            @(negedge sys_clk);
        end
        rd_en = 1'b0;
        chk("R6 still empty", empty, 1);
        burst(1, 1, 16'h3000, 4, 0);
        settle(6);
        drain(2, "R6 no skip");
    endtask

    task automatic t_full();
        burst(4, 4, 16'h4000, 4, 0);
        settle(6);
        chk("R7 full", full, 1);
        chk("R7 not empty", empty, 0);
        pop_check("R7");
        settle(4);
        chk("R7 full drops", full, 0);
        drain(7, "R7");
        burst(4, 4, 16'h5000, 5, 0);
        settle(6);
        chk("R9 refill full", full, 1);
        chk("R9 no overflow", overflow, 0);
        drain(8, "R9");
    endtask

    task automatic t_irregular();
        burst(3, 3, 16'h6000, 7, 60);
        settle(6);
        drain(6, "R8 slow stalled");
        burst(2, 2, 16'h6100, 3, 0);
        #37;
        burst(1, 1, 16'h6200, 9, 25);
        settle(6);
        drain(6, "R8 mixed rate");
    endtask

    task automatic t_concurrent();
        fork
            begin
                burst(2, 2, 16'h7000, 5, 0);
                burst(2, 2, 16'h7100, 3, 20);
                burst(2, 2, 16'h7200, 6, 0);
            end
            begin
                for (int i = 0; i < 12; i++) pop_check("R10 concurrent");
            end
        join
        settle(4);
        chk("R10 empty", empty, 1);
        chk("R10 no overflow", overflow, 0);
    endtask

    task automatic t_overflow();
        burst(5, 4, 16'h8000, 4, 0);
        settle(6);
        chk("R3 overflow set", overflow, 1);
        chk("R3 full", full, 1);
        drain(8, "R3 stored intact");
        chk("R3 overflow sticky", overflow, 1);
        do_reset();
        chk("R3 overflow cleared by reset", overflow, 0);
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_basic_order();
        t_window_gating();
        t_empty_read();
        t_full();
        t_irregular();
        t_concurrent();
        t_overflow();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule